// File: doc/BRIEF.md
# SCSI Bus Controller Host Register File

This block is the host-facing register set of a parallel SCSI bus controller acting as initiator. A host reads and writes eight byte-wide registers through a simple strobe interface. Register writes become the initiator's drive levels on the bus: data-bus enable, ATN, SEL, BSY, ACK and RST, plus the output data byte, the chip mode bits and the expected information-transfer phase. Register reads return live bus levels composed into two status bytes, the latched input byte, and the arbitration progress flags.

The bus lines themselves come from an external target or bus model. The block watches bus-free conditions while arbitration is enabled and raises an arbitration-in-progress flag. If another device drives SEL during arbitration, it raises a lost-arbitration flag. Three sticky event flags (parity error, interrupt, busy error) are collected from pulse inputs. A read of register 7 clears them. DMA address and count logic and interrupt generation live outside this block.

Top module: `scsi_host_regs`

## Requirements
- R1: A write to register 1 sets the drive outputs from the written byte. Bit 0 sets drv_data_en, bit 1 sets drv_atn, bit 2 sets drv_sel, bit 3 sets drv_bsy, bit 4 sets drv_ack and bit 7 sets drv_rst.
- R2: Register 1 reads back the stored drive bits in the positions of R1. Bit 6 reads as arbitration-in-progress and bit 5 as lost arbitration. Writes to bits 6 and 5 have no effect.
- R3: A write to register 0 loads the output byte onto drv_data. A read of register 0 returns bus_data_in as sampled at the read.
- R4: Register 4 reads the live bus status. Bit 7 is drv_rst and bit 6 is bus_bsy_in OR drv_bsy. Bit 5 is REQ, bit 4 MSG, bit 3 C/D and bit 2 I/O. Bit 1 is bus_sel_in OR drv_sel, and bit 0 is bus parity.
- R5: Register 5 reads as follows: bit 0 drv_ack, bit 1 drv_atn, bit 3 phase match, bit 6 dma_req_in and bit 7 zero. Phase match is 1 when register 3 bits 2:0 equal {MSG, C/D, I/O} on the bus.
- R6: On each rising edge of bus_req_in, bus_data_in is captured into an input latch. Register 6 reads this latch, and the latch holds its value until the next rising edge.
- R7: Pulses on evt_parity_err, evt_irq and evt_busy_err set sticky flags. These read in register 5 as bit 5, bit 4 and bit 2. A read of register 7 returns 0x00 and clears all three. An event in the same cycle as that read stays set.
- R8: Register 2 keeps bit 0 (arbitrate, on mode_arbitrate) and bit 1 (DMA mode, on mode_dma); other bits read 0. Register 3 keeps bits 2:0 (tgt_phase); other bits read 0.
- R9: Arbitration-in-progress sets at the second rising clock edge after arbitrate is written to 1, provided bus_bsy_in and bus_sel_in are both low at that edge. Arbitration-in-progress stays clear while the bus is busy.
- R10: Lost arbitration sets on a clock edge where arbitration-in-progress is already 1 and bus_sel_in is high. A write of 0 to register 2 bit 0 clears both flags at that same edge.
- R11: host_rdata and host_rvalid update on the clock edge that samples host_rd. host_rvalid is high for exactly the cycle after each read strobe.
- R12: A synchronous reset clears every register, every flag and every drive output, including drv_rst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Register offset |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 8 | Registered read data |
| host_rvalid | output | 1 | Read data valid |
| bus_data_in | input | 8 | Current bus data byte |
| bus_parity_in | input | 1 | Bus parity line |
| bus_bsy_in | input | 1 | BSY from other devices |
| bus_sel_in | input | 1 | SEL from other devices |
| bus_req_in | input | 1 | REQ from the target |
| bus_msg_in | input | 1 | MSG from the target |
| bus_cd_in | input | 1 | C/D from the target |
| bus_io_in | input | 1 | I/O from the target |
| dma_req_in | input | 1 | DMA request level |
| evt_parity_err | input | 1 | Parity error event pulse |
| evt_irq | input | 1 | Interrupt event pulse |
| evt_busy_err | input | 1 | Busy error event pulse |
| drv_data | output | 8 | Output data byte |
| drv_data_en | output | 1 | Drive data onto the bus |
| drv_atn | output | 1 | Drive ATN |
| drv_sel | output | 1 | Drive SEL |
| drv_bsy | output | 1 | Drive BSY |
| drv_ack | output | 1 | Drive ACK |
| drv_rst | output | 1 | Drive RST |
| mode_arbitrate | output | 1 | Arbitration enabled |
| mode_dma | output | 1 | DMA mode |
| tgt_phase | output | 3 | Expected phase {MSG, C/D, I/O} |

## Verification
A corrupt drive latch appears on the drive pins on the cycle after the write, and in the register 1 and register 4 readbacks on the next read. A stuck or early arbitration flag appears in register 1 bit 6 or 5 the first read after the triggering edge. The bench reads both immediately after the arbitrate write, when the flag must still be 0, and one cycle later. A lost sticky flag or a latch that drifts shows in the next read of register 5 or register 6, two clock edges after the event at most.

// File: rtl/scsi_rf_pkg.sv
package scsi_rf_pkg;

    localparam int unsigned DW = 8;
    localparam int unsigned NUM_REGS = 8;
    localparam int unsigned AW = $clog2(NUM_REGS);

    typedef enum logic [AW-1:0] {
        RG_DATA   = 3'd0,
        RG_ICMD   = 3'd1,
        RG_MODE   = 3'd2,
        RG_TCMD   = 3'd3,
        RG_BUS    = 3'd4,
        RG_BSTAT  = 3'd5,
        RG_INDATA = 3'd6,
        RG_CLRFLG = 3'd7
    } reg_sel_e;

    // Initiator command byte, msb first
    typedef struct packed {
        logic rst;
        logic aip;
        logic la;
        logic ack;
        logic bsy;
        logic sel;
        logic atn;
        logic dbus;
    } icmd_t;

    typedef struct packed {
        logic msg;
        logic cd;
        logic io;
    } phase_t;

    typedef struct packed {
        logic rst;
        logic bsy;
        logic req;
        logic msg;
        logic cd;
        logic io;
        logic sel;
        logic par;
    } busstat_t;

    typedef struct packed {
        logic rsv;
        logic drq;
        logic perr;
        logic irq;
        logic pmatch;
        logic berr;
        logic atn;
        logic ack;
    } bstat_t;

    function automatic logic phase_eq(phase_t a, phase_t b);
        return a == b;
    endfunction

endpackage

// File: rtl/scsi_icmd.sv
module scsi_icmd
    import scsi_rf_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          arb_q,
    input  logic          arb_next,
    input  logic          bus_free,
    input  logic          other_sel,
    output icmd_t         state
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else begin
            if (wr) begin
                state.dbus <= wdata[0];
                state.atn  <= wdata[1];
                state.sel  <= wdata[2];
                state.bsy  <= wdata[3];
                state.ack  <= wdata[4];
                state.rst  <= wdata[7];
            end
            if (!arb_next) begin
                state.aip <= 1'b0;
                state.la  <= 1'b0;
            end else begin
                if (arb_q && bus_free && !state.aip)
                    state.aip <= 1'b1;
                if (state.aip && other_sel)
                    state.la <= 1'b1;
            end
        end
    end

    assert_aip_needs_free_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(state.aip) |-> $past(arb_q && bus_free));

    assert_la_after_aip_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(state.la) |-> $past(state.aip && other_sel));

    assert_flags_off_without_arb_R10: assert property (@(posedge clk) disable iff (rst)
        !arb_q |-> !(state.aip || state.la));

endmodule

// File: rtl/scsi_busstat.sv
module scsi_busstat
    import scsi_rf_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] bus_data_in,
    input  logic          bus_parity_in,
    input  logic          bus_bsy_in,
    input  logic          bus_sel_in,
    input  logic          bus_req_in,
    input  phase_t        bus_phase,
    input  icmd_t         drv,
    input  phase_t        tgt,
    input  logic          dma_req_in,
    input  logic          evt_parity_err,
    input  logic          evt_irq,
    input  logic          evt_busy_err,
    input  logic          clr_flags,
    output busstat_t      bus_o,
    output bstat_t        bst_o,
    output logic [DW-1:0] in_data
);

    logic req_q;
    logic perr_q, irq_q, berr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= 1'b0;
            in_data <= '0;
        end else begin
            req_q <= bus_req_in;
            if (bus_req_in && !req_q)
                in_data <= bus_data_in;
        end
    end

    // Set beats clear so that an event coinciding with the clearing read survives
    always_ff @(posedge clk) begin
        if (rst) begin
            perr_q <= 1'b0;
            irq_q  <= 1'b0;
            berr_q <= 1'b0;
        end else begin
            if (clr_flags) begin
                perr_q <= 1'b0;
                irq_q  <= 1'b0;
                berr_q <= 1'b0;
            end
            if (evt_parity_err) perr_q <= 1'b1;
            if (evt_irq)        irq_q  <= 1'b1;
            if (evt_busy_err)   berr_q <= 1'b1;
        end
    end

    always_comb begin
        bus_o.rst = drv.rst;
        bus_o.bsy = bus_bsy_in | drv.bsy;
        bus_o.req = bus_req_in;
        bus_o.msg = bus_phase.msg;
        bus_o.cd  = bus_phase.cd;
        bus_o.io  = bus_phase.io;
        bus_o.sel = bus_sel_in | drv.sel;
        bus_o.par = bus_parity_in;

        bst_o.rsv    = 1'b0;
        bst_o.drq    = dma_req_in;
        bst_o.perr   = perr_q;
        bst_o.irq    = irq_q;
        bst_o.pmatch = phase_eq(tgt, bus_phase);
        bst_o.berr   = berr_q;
        bst_o.atn    = drv.atn;
        bst_o.ack    = drv.ack;
    end

    assert_clear_on_read_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_flags && !evt_parity_err && !evt_irq && !evt_busy_err)
        |=> !(perr_q || irq_q || berr_q));

    assert_latch_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (!bus_req_in || req_q) |=> $stable(in_data));

endmodule

// File: rtl/scsi_host_regs.sv
module scsi_host_regs
    import scsi_rf_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    host_addr,
    input  logic          host_wr,
    input  logic [7:0]    host_wdata,
    input  logic          host_rd,
    output logic [7:0]    host_rdata,
    output logic          host_rvalid,
    input  logic [7:0]    bus_data_in,
    input  logic          bus_parity_in,
    input  logic          bus_bsy_in,
    input  logic          bus_sel_in,
    input  logic          bus_req_in,
    input  logic          bus_msg_in,
    input  logic          bus_cd_in,
    input  logic          bus_io_in,
    input  logic          dma_req_in,
    input  logic          evt_parity_err,
    input  logic          evt_irq,
    input  logic          evt_busy_err,
    output logic [7:0]    drv_data,
    output logic          drv_data_en,
    output logic          drv_atn,
    output logic          drv_sel,
    output logic          drv_bsy,
    output logic          drv_ack,
    output logic          drv_rst,
    output logic          mode_arbitrate,
    output logic          mode_dma,
    output logic [2:0]    tgt_phase
);

    reg_sel_e sel;
    logic     wr_data, wr_icmd, wr_mode, wr_tcmd, rd_clr;
    logic     arb_q, dma_q, arb_next;
    phase_t   tgt_q, bus_phase;
    logic [DW-1:0] out_q, rd_mux, in_data;
    icmd_t    icmd;
    busstat_t bus_stat;
    bstat_t   bstat;

    assign sel     = reg_sel_e'(host_addr);
    assign wr_data = host_wr && (sel == RG_DATA);
    assign wr_icmd = host_wr && (sel == RG_ICMD);
    assign wr_mode = host_wr && (sel == RG_MODE);
    assign wr_tcmd = host_wr && (sel == RG_TCMD);
    assign rd_clr  = host_rd && (sel == RG_CLRFLG);
    assign arb_next = wr_mode ? host_wdata[0] : arb_q;
    assign bus_phase = '{msg: bus_msg_in, cd: bus_cd_in, io: bus_io_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            arb_q <= 1'b0;
            dma_q <= 1'b0;
            tgt_q <= '0;
        end else begin
            if (wr_data) out_q <= host_wdata;
            if (wr_mode) begin
                arb_q <= host_wdata[0];
                dma_q <= host_wdata[1];
            end
            if (wr_tcmd) tgt_q <= phase_t'(host_wdata[2:0]);
        end
    end

    scsi_icmd u_icmd (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr_icmd),
        .wdata     (host_wdata),
        .arb_q     (arb_q),
        .arb_next  (arb_next),
        .bus_free  (!bus_bsy_in && !bus_sel_in),
        .other_sel (bus_sel_in),
        .state     (icmd)
    );

    scsi_busstat u_stat (
        .clk            (clk),
        .rst            (rst),
        .bus_data_in    (bus_data_in),
        .bus_parity_in  (bus_parity_in),
        .bus_bsy_in     (bus_bsy_in),
        .bus_sel_in     (bus_sel_in),
        .bus_req_in     (bus_req_in),
        .bus_phase      (bus_phase),
        .drv            (icmd),
        .tgt            (tgt_q),
        .dma_req_in     (dma_req_in),
        .evt_parity_err (evt_parity_err),
        .evt_irq        (evt_irq),
        .evt_busy_err   (evt_busy_err),
        .clr_flags      (rd_clr),
        .bus_o          (bus_stat),
        .bst_o          (bstat),
        .in_data        (in_data)
    );

    always_comb begin
        case (sel)
            RG_DATA:   rd_mux = bus_data_in;
            RG_ICMD:   rd_mux = icmd;
            RG_MODE:   rd_mux = {6'b0, dma_q, arb_q};
            RG_TCMD:   rd_mux = {5'b0, tgt_q};
            RG_BUS:    rd_mux = bus_stat;
            RG_BSTAT:  rd_mux = bstat;
            RG_INDATA: rd_mux = in_data;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            host_rvalid <= host_rd;
            if (host_rd) host_rdata <= rd_mux;
        end
    end

    assign drv_data       = out_q;
    assign drv_data_en    = icmd.dbus;
    assign drv_atn        = icmd.atn;
    assign drv_sel        = icmd.sel;
    assign drv_bsy        = icmd.bsy;
    assign drv_ack        = icmd.ack;
    assign drv_rst        = icmd.rst;
    assign mode_arbitrate = arb_q;
    assign mode_dma       = dma_q;
    assign tgt_phase      = tgt_q;

    assert_rvalid_follows_rd_R11: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |-> $past(host_rd));

    assert_icmd_write_lands_R1: assert property (@(posedge clk) disable iff (rst)
        wr_icmd |=> (drv_sel == $past(host_wdata[2]) && drv_rst == $past(host_wdata[7])));

endmodule

// File: tb/scsi_host_regs_tb.sv
module scsi_host_regs_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic       host_rvalid;
    logic [7:0] bus_data_in = '0;
    logic       bus_parity_in = 1'b0, bus_bsy_in = 1'b0, bus_sel_in = 1'b0;
    logic       bus_req_in = 1'b0, bus_msg_in = 1'b0, bus_cd_in = 1'b0, bus_io_in = 1'b0;
    logic       dma_req_in = 1'b0;
    logic       evt_parity_err = 1'b0, evt_irq = 1'b0, evt_busy_err = 1'b0;
    logic [7:0] drv_data;
    logic       drv_data_en, drv_atn, drv_sel, drv_bsy, drv_ack, drv_rst;
    logic       mode_arbitrate, mode_dma;
    logic [2:0] tgt_phase;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [7:0] q_exp[$];
    string      q_tag[$];

    always #4 clk = ~clk;

    scsi_host_regs u_dut (.*);

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: compares each returned read against the queued expectation
    always @(negedge clk) begin
        if (!rst && host_rvalid) begin
            if (q_exp.size() == 0) begin
                total++; bad++;
                $display("FAIL R11: actual=valid expected=no read pending");
            end else begin
                chk(host_rdata, q_exp.pop_front(), q_tag.pop_front());
            end
        end
    end

    // All tasks enter and leave on a falling edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        host_addr = a; host_rd = 1'b1;
        q_exp.push_back(exp); q_tag.push_back(tag);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_drv(input logic [7:0] exp, input string tag);
        chk({drv_rst, 2'b00, drv_ack, drv_bsy, drv_sel, drv_atn, drv_data_en}, exp, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        chk_drv(8'h00, "R12 drives");
        chk(drv_data, 8'h00, "R12 out data");
        chk({mode_dma, mode_arbitrate, 3'b0, tgt_phase}, 8'h00, "R12 mode/phase");
        for (int i = 0; i < 8; i++)
            rd(3'(i), (i == 5) ? 8'h08 : 8'h00, "R12 reg reset value");

        // R1 R2 drive bits and readback, bits 6/5 not writable
        wr(1, 8'hFF);
        chk_drv(8'h9F, "R1 drive pins");
        rd(1, 8'h9F, "R2 readback ignores bits 6,5");
        rd(4, 8'hC2, "R4 own drives in bus status");
        rd(5, 8'h0B, "R5 atn/ack with phase match");
        wr(1, 8'h00);
        chk_drv(8'h00, "R1 drive release");

        // R3 data paths
        wr(0, 8'h5A);
        chk(drv_data, 8'h5A, "R3 output byte");
        bus_data_in = 8'hC3;
        rd(0, 8'hC3, "R3 live bus data");

        // R8 mode and target phase
        wr(2, 8'h02);
        chk({6'b0, mode_dma, mode_arbitrate}, 8'h02, "R8 mode pins");
        rd(2, 8'h02, "R8 mode readback");
        wr(2, 8'hFE);
        rd(2, 8'h02, "R8 mode unused bits");
        wr(2, 8'h00);
        wr(3, 8'hFD);
        chk({5'b0, tgt_phase}, 8'h05, "R8 tgt pins");
        rd(3, 8'h05, "R8 tgt readback");

        // R5 phase match / mismatch
        bus_msg_in = 1'b1; bus_io_in = 1'b1;
        rd(5, 8'h08, "R5 phase match");
        bus_cd_in = 1'b1;
        rd(5, 8'h00, "R5 phase mismatch");
        bus_cd_in = 1'b0;

        // R4 composite bus status, R6 latch on req rise
        bus_bsy_in = 1'b1; bus_req_in = 1'b1; bus_parity_in = 1'b1;
        rd(4, 8'h75, "R4 bus status lines");
        rd(6, 8'hC3, "R6 latch on req rise");
        bus_data_in = 8'h11;
        idle(1);
        rd(6, 8'hC3, "R6 latch holds while req high");
        bus_req_in = 1'b0; bus_data_in = 8'h3C;
        idle(1);
        bus_req_in = 1'b1;
        idle(1);
        rd(6, 8'h3C, "R6 second capture");

        // R5 DRQ
        dma_req_in = 1'b1;
        rd(5, 8'h48, "R5 drq bit");
        dma_req_in = 1'b0;
        bus_bsy_in = 1'b0; bus_req_in = 1'b0; bus_parity_in = 1'b0;
        bus_msg_in = 1'b0; bus_io_in = 1'b0;

        // R7 sticky flags
        evt_parity_err = 1'b1; idle(1); evt_parity_err = 1'b0;
        rd(5, 8'h20, "R7 parity flag");
        evt_irq = 1'b1; evt_busy_err = 1'b1; idle(1);
        evt_irq = 1'b0; evt_busy_err = 1'b0;
        rd(5, 8'h34, "R7 all flags");
        rd(7, 8'h00, "R7 clear read returns zero");
        rd(5, 8'h00, "R7 flags cleared");
        evt_irq = 1'b1;
        rd(7, 8'h00, "R7 clear with event");
        evt_irq = 1'b0;
        rd(5, 8'h10, "R7 coincident event kept");
        rd(7, 8'h00, "R7 tidy");

        // R9 R10 arbitration
        wr(0, 8'h80);
        wr(2, 8'h01);
        rd(1, 8'h00, "R9 aip not yet set");
        rd(1, 8'h40, "R9 aip set");
        bus_sel_in = 1'b1;
        idle(1);
        rd(1, 8'h60, "R10 lost arbitration");
        wr(2, 8'h00);
        rd(1, 8'h00, "R10 flags cleared by arb off");
        bus_sel_in = 1'b0;
        bus_bsy_in = 1'b1;
        wr(2, 8'h01);
        idle(3);
        rd(1, 8'h00, "R9 no aip on busy bus");
        wr(2, 8'h00);
        bus_bsy_in = 1'b0;

        // R12 reset mid-run
        wr(1, 8'h9F);
        wr(3, 8'h07);
        idle(2);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk_drv(8'h00, "R12 drives after reset");
        chk({5'b0, tgt_phase}, 8'h00, "R12 tgt after reset");
        rd(1, 8'h00, "R12 icmd after reset");

        idle(3);
        total++;
        if (q_exp.size() != 0) begin
            bad++;
            $display("FAIL R11: actual=%0d pending expected=0", q_exp.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule